// File: doc/BRIEF.md
# Inter-Core Command Router

This block carries commands from one issuing core to any of `N_CORES` worker cores and carries the workers' answers back. The issuer presents a command as a payload plus a worker number on a valid/ready channel. A tree of registered fan-out stages delivers it to the addressed worker's own valid/ready command port. Each stage has at most `MAX_FANOUT` outputs, and every stage adds one register, so an unobstructed command always takes the same number of cycles. The tree has `LVLS` levels: the smallest count for which `MAX_FANOUT^LVLS >= N_CORES`. With the defaults of 6 workers and a fanout of 2, that is 3 levels.

Commands flow one way only, and the issuer is the only source of commands for the workers. Each worker returns responses on its own valid/ready output. A round-robin merger places these responses in a single registered slot, which the issuer drains. A command whose worker number is out of range is taken and discarded, and it sets a flag that only reset clears.

Back-pressure rules apply to every channel. A transfer happens on a rising edge where valid and ready are both high. While valid is high and ready is low, the sender holds the payload steady. The router's `req_ready_o` depends on the addressed path. `wrk_rsp_ready_o` is a grant, and it is raised only toward a worker that is presenting a response.

Top module: `icc_cmd_router`

## Requirements
- R1: A command taken with worker number c < N_CORES appears only on worker port c, with its payload unchanged. If nothing stalls, `wrk_cmd_valid_o[c]` rises after LVLS rising edges, counting the accepting edge as the first. LVLS is 3 with the defaults.
- R2: Each in-range command is delivered exactly once. Commands to the same worker are delivered in the order they were issued.
- R3: While a worker holds its command ready low, that worker's command valid stays high and its payload does not change.
- R4: A command with worker number >= N_CORES has `req_ready_o` high in the same cycle, whatever the workers are doing. It reaches no worker, and `bad_target_o` is high from the next edge.
- R5: After reset, all worker command valids, `rsp_valid_o` and `bad_target_o` are low. Once `bad_target_o` is set, it stays high until reset.
- R6: A response taken from worker w appears on the issuer response port at the next edge, with the same data and with `rsp_core_o` = w. A worker's response ready is high only while its response valid is high and the slot is empty or being drained.
- R7: At most one worker response ready is high per cycle. The search starts at the worker after the last one granted, and worker 0 comes first after reset.
- R8: While `rsp_ready_i` is low, `rsp_valid_o`, `rsp_data_o` and `rsp_core_o` hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Issuer command valid |
| req_ready_o | output | 1 | Router can take the command |
| req_core_i | input | IDX_W | Target worker number |
| req_payload_i | input | PAYLOAD_W | Command payload |
| rsp_valid_o | output | 1 | Response slot holds a response |
| rsp_ready_i | input | 1 | Issuer drains the response |
| rsp_data_o | output | RESP_W | Response data |
| rsp_core_o | output | IDX_W | Worker that produced the response |
| wrk_cmd_valid_o | output | N_CORES | Per-worker command valid |
| wrk_cmd_ready_i | input | N_CORES | Per-worker command ready |
| wrk_cmd_payload_o | output | N_CORES x PAYLOAD_W | Per-worker command payload |
| wrk_rsp_valid_i | input | N_CORES | Per-worker response valid |
| wrk_rsp_ready_o | output | N_CORES | Per-worker response grant |
| wrk_rsp_data_i | input | N_CORES x RESP_W | Per-worker response data |
| bad_target_o | output | 1 | Sticky out-of-range target flag |

## Verification
Two things can fall in the same cycle: a new command entering the tree while earlier commands are still moving down it, and several workers presenting responses while the issuer is draining the slot. To provoke the first, the bench issues commands back to back, with some out-of-range numbers mixed in, while randomly throttling the worker readies. To provoke the second, it loads response queues for all workers at once and toggles `rsp_ready_i`. A behavioural model judges both. It keeps per-worker expected-command queues and tracks the round-robin pointer and slot state, and it compares grants, the slot contents and the delivery order on every cycle.

// File: rtl/icc_router_pkg.sv
package icc_router_pkg;

  function automatic int ipow(input int b, input int e);
    int r;
    r = 1;
    for (int i = 0; i < e; i++) r = r * b;
    return r;
  endfunction

  // smallest depth whose fanout covers n leaves
  function automatic int tree_levels(input int n, input int d);
    int l;
    int cap;
    l = 1;
    cap = d;
    while (cap < n) begin
      cap = cap * d;
      l = l + 1;
    end
    return l;
  endfunction

  // index of the first node of level l in a flattened tree
  function automatic int level_base(input int l, input int d);
    int s;
    s = 0;
    for (int i = 0; i < l; i++) s = s + ipow(d, i);
    return s;
  endfunction

endpackage

// File: rtl/icc_fanout_stage.sv
module icc_fanout_stage #(
  parameter int DEG   = 2,
  parameter int IDX_W = 3,
  parameter int PW    = 16,
  parameter int DIV   = 1
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      in_valid,
  output logic                      in_ready,
  input  logic [IDX_W-1:0]          in_idx,
  input  logic [PW-1:0]             in_payload,
  output logic [DEG-1:0]            out_valid,
  input  logic [DEG-1:0]            out_ready,
  output logic [DEG-1:0][IDX_W-1:0] out_idx,
  output logic [DEG-1:0][PW-1:0]    out_payload
);
  localparam int SEL_W = (DEG > 1) ? $clog2(DEG) : 1;

  logic [IDX_W-1:0] digit;
  logic [SEL_W-1:0] sel;
  logic             take;
  logic [DEG-1:0]            v_q;
  logic [DEG-1:0][IDX_W-1:0] idx_q;
  logic [DEG-1:0][PW-1:0]    pl_q;

  // digit of the worker number that belongs to this level
  assign digit = (in_idx / IDX_W'(DIV)) % IDX_W'(DEG);

  always_comb begin
    sel = '0;
    for (int k = 0; k < DEG; k++)
      if (digit == IDX_W'(k)) sel = SEL_W'(k);
  end

  assign in_ready = !v_q[sel] || out_ready[sel];
  assign take     = in_valid && in_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      v_q <= '0;
    end else begin
      for (int k = 0; k < DEG; k++) begin
        if (out_ready[k]) v_q[k] <= 1'b0;
        if (take && sel == SEL_W'(k)) v_q[k] <= 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    for (int k = 0; k < DEG; k++)
      if (take && sel == SEL_W'(k)) begin
        idx_q[k] <= in_idx;
        pl_q[k]  <= in_payload;
      end
  end

  assign out_valid   = v_q;
  assign out_idx     = idx_q;
  assign out_payload = pl_q;

  for (genvar k = 0; k < DEG; k++) begin : g_chk
    // R1
    route_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && in_ready && sel == SEL_W'(k)) |=>
        (out_valid[k] && out_payload[k] == $past(in_payload)));
    // R3
    hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid[k] && !out_ready[k]) |=>
        (out_valid[k] && $stable(out_payload[k]) && $stable(out_idx[k])));
  end

endmodule

// File: rtl/icc_resp_merge.sv
module icc_resp_merge #(
  parameter int N     = 6,
  parameter int RW    = 12,
  parameter int SRC_W = 3
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [N-1:0]         in_valid,
  output logic [N-1:0]         in_ready,
  input  logic [N-1:0][RW-1:0] in_data,
  output logic                 out_valid,
  input  logic                 out_ready,
  output logic [RW-1:0]        out_data,
  output logic [SRC_W-1:0]     out_src
);
  logic [SRC_W-1:0] ptr_q;
  logic [SRC_W-1:0] gsel;
  logic [N-1:0]     gnt;
  logic             found;
  logic             slot_free;
  logic             ov_q;
  logic [RW-1:0]    od_q;
  logic [SRC_W-1:0] os_q;

  assign slot_free = !ov_q || out_ready;

  always_comb begin
    int c;
    gnt   = '0;
    gsel  = ptr_q;
    found = 1'b0;
    for (int k = 1; k <= N; k++) begin
      c = (int'(ptr_q) + k) % N;
      if (slot_free && !found && in_valid[c]) begin
        found  = 1'b1;
        gnt[c] = 1'b1;
        gsel   = SRC_W'(c);
      end
    end
  end

  assign in_ready = gnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ov_q  <= 1'b0;
      ptr_q <= SRC_W'(N - 1);
    end else begin
      if (out_ready) ov_q <= 1'b0;
      if (found) begin
        ov_q  <= 1'b1;
        ptr_q <= gsel;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (found) begin
      od_q <= in_data[gsel];
      os_q <= gsel;
    end
  end

  assign out_valid = ov_q;
  assign out_data  = od_q;
  assign out_src   = os_q;

  // R7
  grant_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(in_ready));

  // R8
  rsp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=>
      (out_valid && $stable(out_data) && $stable(out_src)));

  for (genvar w = 0; w < N; w++) begin : g_cap
    // R6
    capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid[w] && in_ready[w]) |=>
        (out_valid && out_src == SRC_W'(w) && out_data == $past(in_data[w])));
  end

endmodule

// File: rtl/icc_cmd_router.sv
module icc_cmd_router
  import icc_router_pkg::*;
#(
  parameter int N_CORES    = 6,
  parameter int MAX_FANOUT = 2,
  parameter int PAYLOAD_W  = 16,
  parameter int RESP_W     = 12,
  parameter int IDX_W      = $clog2(N_CORES)
) (
  input  logic                                clk,
  input  logic                                rst_n,
  input  logic                                req_valid_i,
  output logic                                req_ready_o,
  input  logic [IDX_W-1:0]                    req_core_i,
  input  logic [PAYLOAD_W-1:0]                req_payload_i,
  output logic                                rsp_valid_o,
  input  logic                                rsp_ready_i,
  output logic [RESP_W-1:0]                   rsp_data_o,
  output logic [IDX_W-1:0]                    rsp_core_o,
  output logic [N_CORES-1:0]                  wrk_cmd_valid_o,
  input  logic [N_CORES-1:0]                  wrk_cmd_ready_i,
  output logic [N_CORES-1:0][PAYLOAD_W-1:0]   wrk_cmd_payload_o,
  input  logic [N_CORES-1:0]                  wrk_rsp_valid_i,
  output logic [N_CORES-1:0]                  wrk_rsp_ready_o,
  input  logic [N_CORES-1:0][RESP_W-1:0]      wrk_rsp_data_i,
  output logic                                bad_target_o
);
  localparam int LVLS = tree_levels(N_CORES, MAX_FANOUT);
  localparam int TOT  = level_base(LVLS, MAX_FANOUT);

  logic                 nd_in_v   [TOT];
  logic                 nd_in_r   [TOT];
  logic [IDX_W-1:0]     nd_in_idx [TOT];
  logic [PAYLOAD_W-1:0] nd_in_pl  [TOT];
  logic [MAX_FANOUT-1:0]                nd_out_v   [TOT];
  logic [MAX_FANOUT-1:0][IDX_W-1:0]     nd_out_idx [TOT];
  logic [MAX_FANOUT-1:0][PAYLOAD_W-1:0] nd_out_pl  [TOT];

  logic in_range;
  logic err_q;

  assign in_range = {1'b0, req_core_i} < (IDX_W + 1)'(N_CORES);

  // root feed: out-of-range commands are swallowed here
  assign nd_in_v[0]   = req_valid_i && in_range;
  assign nd_in_idx[0] = req_core_i;
  assign nd_in_pl[0]  = req_payload_i;
  assign req_ready_o  = in_range ? nd_in_r[0] : 1'b1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                         err_q <= 1'b0;
    else if (req_valid_i && !in_range)  err_q <= 1'b1;
  end
  assign bad_target_o = err_q;

  for (genvar l = 0; l < LVLS; l++) begin : g_lvl
    for (genvar j = 0; j < ipow(MAX_FANOUT, l); j++) begin : g_node
      localparam int G = level_base(l, MAX_FANOUT) + j;
      logic [MAX_FANOUT-1:0] ordy;

      if (l > 0) begin : g_link
        localparam int P = level_base(l - 1, MAX_FANOUT) + j / MAX_FANOUT;
        localparam int K = j % MAX_FANOUT;
        assign nd_in_v[G]   = nd_out_v[P][K];
        assign nd_in_idx[G] = nd_out_idx[P][K];
        assign nd_in_pl[G]  = nd_out_pl[P][K];
      end

      icc_fanout_stage #(
        .DEG  (MAX_FANOUT),
        .IDX_W(IDX_W),
        .PW   (PAYLOAD_W),
        .DIV  (ipow(MAX_FANOUT, LVLS - 1 - l))
      ) u_stage (
        .clk        (clk),
        .rst_n      (rst_n),
        .in_valid   (nd_in_v[G]),
        .in_ready   (nd_in_r[G]),
        .in_idx     (nd_in_idx[G]),
        .in_payload (nd_in_pl[G]),
        .out_valid  (nd_out_v[G]),
        .out_ready  (ordy),
        .out_idx    (nd_out_idx[G]),
        .out_payload(nd_out_pl[G])
      );

      for (genvar k = 0; k < MAX_FANOUT; k++) begin : g_out
        if (l < LVLS - 1) begin : g_inner
          assign ordy[k] = nd_in_r[level_base(l + 1, MAX_FANOUT) + j * MAX_FANOUT + k];
        end else begin : g_leaf
          localparam int W = j * MAX_FANOUT + k;
          if (W < N_CORES) begin : g_live
            logic unused_idx;
            assign wrk_cmd_valid_o[W]   = nd_out_v[G][k];
            assign wrk_cmd_payload_o[W] = nd_out_pl[G][k];
            assign ordy[k]              = wrk_cmd_ready_i[W];
            assign unused_idx           = ^nd_out_idx[G][k];
          end else begin : g_void
            logic unused_tail;
            assign ordy[k]     = 1'b1;
            assign unused_tail = nd_out_v[G][k] ^ (^nd_out_pl[G][k]) ^ (^nd_out_idx[G][k]);
          end
        end
      end
    end
  end

  icc_resp_merge #(
    .N    (N_CORES),
    .RW   (RESP_W),
    .SRC_W(IDX_W)
  ) u_merge (
    .clk      (clk),
    .rst_n    (rst_n),
    .in_valid (wrk_rsp_valid_i),
    .in_ready (wrk_rsp_ready_o),
    .in_data  (wrk_rsp_data_i),
    .out_valid(rsp_valid_o),
    .out_ready(rsp_ready_i),
    .out_data (rsp_data_o),
    .out_src  (rsp_core_o)
  );

  // R4
  bad_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid_i && !in_range) |-> req_ready_o);
  // R4
  err_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid_i && !in_range) |=> bad_target_o);
  // R5
  err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bad_target_o |=> bad_target_o);

endmodule

// File: tb/icc_cmd_router_tb_top.sv
`timescale 1ns/1ps
module icc_cmd_router_tb_top;
  localparam int N   = 6;
  localparam int PW  = 16;
  localparam int RW  = 12;
  localparam int IW  = 3;
  localparam int LAT = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic              req_valid = 1'b0;
  logic              req_ready;
  logic [IW-1:0]     req_core = '0;
  logic [PW-1:0]     req_payload = '0;
  logic              rsp_valid;
  logic              rsp_ready = 1'b1;
  logic [RW-1:0]     rsp_data;
  logic [IW-1:0]     rsp_core;
  logic [N-1:0]      wc_valid;
  logic [N-1:0]      wc_ready = '1;
  logic [N-1:0][PW-1:0] wc_pl;
  logic [N-1:0]      wr_valid = '0;
  logic [N-1:0]      wr_ready;
  logic [N-1:0][RW-1:0] wr_data = '0;
  logic              bad;

  icc_cmd_router dut_i (
    .clk(clk), .rst_n(rst_n),
    .req_valid_i(req_valid), .req_ready_o(req_ready),
    .req_core_i(req_core), .req_payload_i(req_payload),
    .rsp_valid_o(rsp_valid), .rsp_ready_i(rsp_ready),
    .rsp_data_o(rsp_data), .rsp_core_o(rsp_core),
    .wrk_cmd_valid_o(wc_valid), .wrk_cmd_ready_i(wc_ready),
    .wrk_cmd_payload_o(wc_pl),
    .wrk_rsp_valid_i(wr_valid), .wrk_rsp_ready_o(wr_ready),
    .wrk_rsp_data_i(wr_data),
    .bad_target_o(bad)
  );

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  bit mon_on = 0, lat_on = 0, rnd_cmd = 0, rnd_rsp = 0;
  int last_waits;

  logic [PW-1:0] eq [N][$];
  int            tq [N][$];
  logic [RW-1:0] rq [N][$];

  // response model state
  bit            mv = 0;
  logic [RW-1:0] md;
  int            ms, ptr = N - 1;
  bit            rsp_stalled = 0;
  bit            pst [N];
  logic [PW-1:0] pdat [N];

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  always @(posedge clk) cyc = cyc + 1;

  // drive at negedge, observe just before the next rising edge
  always begin
    @(negedge clk);
    wc_ready  = rnd_cmd ? N'($urandom) : '1;
    rsp_ready = rnd_rsp ? 1'($urandom) : 1'b1;
    for (int w = 0; w < N; w++) begin
      wr_valid[w] = rq[w].size() > 0;
      wr_data[w]  = (rq[w].size() > 0) ? rq[w][0] : '0;
    end
    #2;
    if (mon_on && rst_n) begin
      int g;
      logic [N-1:0] eg;
      bit free;
      for (int w = 0; w < N; w++) begin
        if (pst[w]) chk(wc_valid[w] && wc_pl[w] == pdat[w], "R3", "stalled cmd held",
                        {wc_valid[w], wc_pl[w]}, {1'b1, pdat[w]});
        pst[w]  = wc_valid[w] && !wc_ready[w];
        pdat[w] = wc_pl[w];
        if (wc_valid[w] && wc_ready[w]) begin
          if (eq[w].size() == 0) begin
            chk(0, "R2", "unexpected cmd at worker", w, 0);
          end else begin
            chk(wc_pl[w] == eq[w][0], "R2", "cmd order/payload", wc_pl[w], eq[w][0]);
            if (lat_on) chk(cyc - tq[w][0] == LAT, "R1", "delivery latency",
                            cyc - tq[w][0], LAT);
            void'(eq[w].pop_front());
            void'(tq[w].pop_front());
          end
        end
      end
      chk(rsp_valid == mv, "R6", "rsp valid", rsp_valid, mv);
      if (mv) begin
        chk(rsp_data == md && int'(rsp_core) == ms, rsp_stalled ? "R8" : "R6",
            "rsp data/core", {rsp_core, rsp_data}, {IW'(ms), md});
      end
      free = !mv || rsp_ready;
      g = -1;
      if (free)
        for (int k = 1; k <= N; k++)
          if (g < 0 && wr_valid[(ptr + k) % N]) g = (ptr + k) % N;
      eg = '0;
      if (g >= 0) eg[g] = 1'b1;
      chk(wr_ready == eg, "R7", "response grant", wr_ready, eg);
      rsp_stalled = mv && !rsp_ready;
      if (mv && rsp_ready) mv = 0;
      if (g >= 0) begin
        mv = 1; md = rq[g][0]; ms = g; ptr = g;
        void'(rq[g].pop_front());
      end
    end
  end

  task automatic send(input int idx, input logic [PW-1:0] p);
    int waits;
    @(negedge clk);
    req_valid = 1'b1; req_core = IW'(idx); req_payload = p;
    waits = 0;
    forever begin
      #2;
      if (req_ready) break;
      waits++;
      @(negedge clk);
    end
    if (idx < N) begin
      eq[idx].push_back(p);
      tq[idx].push_back(cyc);
    end
    last_waits = waits;
  endtask

  task automatic idle();
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  function automatic int pending();
    int s;
    s = 0;
    for (int w = 0; w < N; w++) s += eq[w].size() + rq[w].size();
    return s + int'(mv);
  endfunction

  task automatic summary();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=timeout expected=finished");
    summary();
    $finish;
  end

  initial begin
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    #2;
    // R5 reset state
    chk(wc_valid == '0, "R5", "worker valids after reset", wc_valid, 0);
    chk(rsp_valid == 1'b0, "R5", "rsp valid after reset", rsp_valid, 0);
    chk(bad == 1'b0, "R5", "flag after reset", bad, 0);
    mon_on = 1;

    // R1 unobstructed latency, every worker
    lat_on = 1;
    for (int w = 0; w < N; w++) begin
      send(w, PW'(16'hA000 + w));
      idle();
      repeat (6) @(negedge clk);
    end
    lat_on = 0;
    chk(pending() == 0, "R1", "all single cmds delivered", pending(), 0);

    // R4 out-of-range targets
    chk(bad == 1'b0, "R4", "flag before bad cmd", bad, 0);
    send(6, 16'hBAD6);
    chk(last_waits == 0, "R4", "bad cmd ready at once", last_waits, 0);
    idle();
    #2;
    chk(bad == 1'b1, "R4", "flag after bad cmd", bad, 1);
    send(7, 16'hBAD7);
    chk(last_waits == 0, "R4", "bad cmd ready at once", last_waits, 0);
    idle();
    repeat (8) @(negedge clk);
    chk(wc_valid == '0 && pending() == 0, "R4", "bad cmds reached no worker", wc_valid, 0);

    // R2 R3 back-to-back traffic under random worker stalls
    rnd_cmd = 1;
    for (int i = 0; i < 300; i++) begin
      int t;
      t = ((i % 40) < 10) ? 2 : int'($urandom % 8);
      send(t, PW'(i));
      if (t >= N) chk(last_waits == 0, "R4", "bad cmd ready under stall", last_waits, 0);
      if (i % 17 == 0) idle();
    end
    idle();
    rnd_cmd = 0;
    repeat (30) @(negedge clk);
    chk(pending() == 0, "R2", "all stressed cmds delivered", pending(), 0);
    chk(bad == 1'b1, "R5", "flag stays set", bad, 1);

    // R6 R7 every worker answering at once, issuer always ready
    @(posedge clk); #1;
    for (int w = 0; w < N; w++)
      for (int i = 0; i < 3; i++) rq[w].push_back(RW'((w << 8) | i));
    for (int i = 0; i < 200 && pending() != 0; i++) @(negedge clk);
    chk(pending() == 0, "R7", "simultaneous responses drained", pending(), 0);

    // R6 R8 staggered responses, issuer throttled
    rnd_rsp = 1;
    for (int r = 0; r < 5; r++) begin
      @(posedge clk); #1;
      for (int w = r % 2; w < N; w += 1 + (r % 3))
        for (int i = 0; i < 4; i++) rq[w].push_back(RW'((r << 8) | (w << 4) | i));
      repeat (7) @(negedge clk);
    end
    for (int i = 0; i < 500 && pending() != 0; i++) @(negedge clk);
    rnd_rsp = 0;
    repeat (3) @(negedge clk);
    chk(pending() == 0, "R8", "throttled responses drained", pending(), 0);
    chk(bad == 1'b1, "R5", "flag still set at end", bad, 1);

    summary();
    $finish;
  end
endmodule